// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM Core

This block is a synchronous static RAM whose data port runs at double data rate. Every access moves a pair of adjacent words. A command is taken on the rising clock edge. An active-low load strobe starts an access, and a read/write select chooses its direction. The supplied address names a word pair. The first word of the pair sits at the address with a low bit of 0 appended, and the second word at the same address with a low bit of 1 appended.

Write data enters on both clock edges and is parked in a posted-write holding stage. That stage is written into the array only when the next write command arrives. Reads consult the holding stage lane by lane, so a read always returns the newest data, even one clock after the write. Read data leaves on both clock edges. A pin selects one of two latencies: one full cycle, or one and a half cycles.

Top module: `ddr_pair_sram`

## Requirements
- R1: At a rising edge, `ld_n`=0 with `rd_nwr`=1 starts a read and `ld_n`=0 with `rd_nwr`=0 starts a write. With `ld_n`=1, no access starts: memory is unchanged and no read beats are produced for that slot.
- R2: For a write, beat 0 (`wdata`, `lane_we`) is sampled at the command's rising edge and is stored at word {addr,0}. Beat 1 is sampled at the following falling edge and is stored at word {addr,1}.
- R3: Bit i of `lane_we` (1 = store) governs data bits [9i+8:9i] of its beat. A lane whose bit is 0 keeps its previous contents, so an all-zero mask leaves both words untouched.
- R4: A read delivers word {addr,0} as its first beat and word {addr,1} as its second beat.
- R5: With `lat_sel`=0, the first beat is on `rdata` in the high phase after the first rising edge that follows the command edge. The second beat follows in the next low phase.
- R6: With `lat_sel`=1, the first beat is on `rdata` in the low phase after the first rising edge that follows the command edge. The second beat follows in the next high phase.
- R7: `rvalid` is 1 exactly during the phases in which read beats are on `rdata`. It is 0 otherwise, and it is 0 out of reset.
- R8: Writes are posted and are committed to the array when the next write command is accepted. A read whose address matches the posted write returns, per lane, the posted data where that lane was enabled and the array data elsewhere. This holds even for a read issued in the cycle right after the write.
- R9: Commands may arrive on every consecutive rising edge, in any mix of reads and writes. Each produces its own result without stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge takes commands and beat 0, falling edge takes beat 1 |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| ld_n | input | 1 | Active-low access start strobe |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Word-pair address |
| wdata | input | DW | Write data, one beat per clock edge |
| lane_we | input | NB | Per-lane store enables of the current write beat |
| lat_sel | input | 1 | Read latency: 0 = one cycle, 1 = one and a half cycles |
| rdata | output | DW | Read data, one beat per clock phase |
| rvalid | output | 1 | High while a read beat is on rdata |

## Verification
The bench builds the core with AW=3, DW=36 and NB=4, which gives 8 word pairs and four 9-bit lanes. That address space is small enough for a random command mix to land repeatedly on the address held in the posted-write stage. Forwarding, partial-lane merging and the commit-on-next-write path are therefore all exercised, not only the bulk fill. The full sequence runs once with each setting of `lat_sel`, with a reset between the two passes. Both beats of every read are compared against a byte-masked reference memory, at the exact clock phase each latency prescribes.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } dpr_op_e;
endpackage

// File: rtl/dpr_array.sv
`timescale 1ns/1ps
module dpr_array #(
   parameter int AW = 4,
   parameter int DW = 36,
   parameter int NB = 4
) (
   input  logic          clk,
   input  logic          commit,
   input  logic [AW-1:0] c_addr,
   input  logic [DW-1:0] c_w0,
   input  logic [DW-1:0] c_w1,
   input  logic [NB-1:0] c_m0,
   input  logic [NB-1:0] c_m1,
   input  logic [AW-1:0] r_addr,
   output logic [DW-1:0] r_w0,
   output logic [DW-1:0] r_w1
);
   localparam int LW    = DW / NB;
   localparam int WORDS = 2 ** (AW + 1);

   logic [DW-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (commit) begin
         for (int l = 0; l < NB; l++) begin
            if (c_m0[l]) mem[{c_addr, 1'b0}][l*LW +: LW] <= c_w0[l*LW +: LW];
            if (c_m1[l]) mem[{c_addr, 1'b1}][l*LW +: LW] <= c_w1[l*LW +: LW];
         end
      end
   end

   assign r_w0 = mem[{r_addr, 1'b0}];
   assign r_w1 = mem[{r_addr, 1'b1}];
endmodule

// File: rtl/dpr_post_buf.sv
`timescale 1ns/1ps
module dpr_post_buf #(
   parameter int AW = 4,
   parameter int DW = 36,
   parameter int NB = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_cmd,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wd,
   input  logic [NB-1:0] we,
   input  logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] arr_w0,
   input  logic [DW-1:0] arr_w1,
   output logic          pend_vld,
   output logic [AW-1:0] pend_addr,
   output logic [DW-1:0] pend_w0,
   output logic [DW-1:0] pend_w1,
   output logic [NB-1:0] pend_m0,
   output logic [NB-1:0] pend_m1,
   output logic [DW-1:0] fwd_w0,
   output logic [DW-1:0] fwd_w1
);
   localparam int LW = DW / NB;

   logic wr_seen;
   logic hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_vld  <= 1'b0;
         pend_addr <= '0;
         pend_w0   <= '0;
         pend_m0   <= '0;
         wr_seen   <= 1'b0;
      end else begin
         wr_seen <= wr_cmd;
         if (wr_cmd) begin
            pend_vld  <= 1'b1;
            pend_addr <= addr;
            pend_w0   <= wd;
            pend_m0   <= we;
         end
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_w1 <= '0;
         pend_m1 <= '0;
      end else if (wr_seen) begin
         pend_w1 <= wd;
         pend_m1 <= we;
      end
   end

   assign hit = pend_vld && (pend_addr == rd_addr);

   for (genvar l = 0; l < NB; l++) begin : g_lane
      assign fwd_w0[l*LW +: LW] = (hit && pend_m0[l]) ? pend_w0[l*LW +: LW] : arr_w0[l*LW +: LW];
      assign fwd_w1[l*LW +: LW] = (hit && pend_m1[l]) ? pend_w1[l*LW +: LW] : arr_w1[l*LW +: LW];
   end

   // R8: a full-mask hit must hand back the posted word rather than the array word
   p_full_hit_forwards_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_vld && pend_addr == rd_addr && (&pend_m0)) |-> (fwd_w0 == pend_w0));
endmodule

// File: rtl/dpr_rd_pipe.sv
`timescale 1ns/1ps
module dpr_rd_pipe #(
   parameter int DW = 36
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lat_sel,
   input  logic          ld_v,
   input  logic [DW-1:0] ld_w0,
   input  logic [DW-1:0] ld_w1,
   output logic [DW-1:0] q_pos,
   output logic [DW-1:0] q_neg,
   output logic          v_pos,
   output logic          v_neg
);
   logic          st0_v, s1_v;
   logic [DW-1:0] st0_w0, st0_w1, s1_w0, s1_w1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st0_v  <= 1'b0;
         st0_w0 <= '0;
         st0_w1 <= '0;
         s1_v   <= 1'b0;
         s1_w0  <= '0;
         s1_w1  <= '0;
         v_pos  <= 1'b0;
         q_pos  <= '0;
      end else begin
         st0_v <= ld_v;
         if (ld_v) begin
            st0_w0 <= ld_w0;
            st0_w1 <= ld_w1;
         end
         s1_v  <= st0_v;
         s1_w0 <= st0_w0;
         s1_w1 <= st0_w1;
         v_pos <= lat_sel ? s1_v  : st0_v;
         q_pos <= lat_sel ? s1_w1 : st0_w0;
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_neg <= 1'b0;
         q_neg <= '0;
      end else begin
         v_neg <= s1_v;
         q_neg <= lat_sel ? s1_w0 : s1_w1;
      end
   end
endmodule

// File: rtl/ddr_pair_sram.sv
`timescale 1ns/1ps
module ddr_pair_sram #(
   parameter int AW = 6,
   parameter int DW = 36,
   parameter int NB = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_n,
   input  logic          rd_nwr,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [NB-1:0] lane_we,
   input  logic          lat_sel,
   output logic [DW-1:0] rdata,
   output logic          rvalid
);
   import dpr_pkg::*;

   if (DW % NB != 0) begin : g_bad_lanes
      $error("DW must split evenly into NB lanes");
   end
   if (AW < 1) begin : g_bad_aw
      $error("AW must be at least 1");
   end

   dpr_op_e op;
   logic    rd_cmd, wr_cmd, commit;

   assign op     = ld_n ? OP_NONE : (rd_nwr ? OP_READ : OP_WRITE);
   assign rd_cmd = (op == OP_READ);
   assign wr_cmd = (op == OP_WRITE);

   logic          pend_vld;
   logic [AW-1:0] pend_addr;
   logic [DW-1:0] pend_w0, pend_w1, arr_w0, arr_w1, fwd_w0, fwd_w1;
   logic [NB-1:0] pend_m0, pend_m1;
   logic [DW-1:0] q_pos, q_neg;
   logic          v_pos, v_neg;

   assign commit = wr_cmd && pend_vld;

   dpr_array #(.AW(AW), .DW(DW), .NB(NB)) u_array (
      .clk(clk), .commit(commit), .c_addr(pend_addr),
      .c_w0(pend_w0), .c_w1(pend_w1), .c_m0(pend_m0), .c_m1(pend_m1),
      .r_addr(addr), .r_w0(arr_w0), .r_w1(arr_w1)
   );

   dpr_post_buf #(.AW(AW), .DW(DW), .NB(NB)) u_post (
      .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .addr(addr), .wd(wdata), .we(lane_we),
      .rd_addr(addr), .arr_w0(arr_w0), .arr_w1(arr_w1),
      .pend_vld(pend_vld), .pend_addr(pend_addr), .pend_w0(pend_w0), .pend_w1(pend_w1),
      .pend_m0(pend_m0), .pend_m1(pend_m1), .fwd_w0(fwd_w0), .fwd_w1(fwd_w1)
   );

   dpr_rd_pipe #(.DW(DW)) u_pipe (
      .clk(clk), .rst_n(rst_n), .lat_sel(lat_sel), .ld_v(rd_cmd),
      .ld_w0(fwd_w0), .ld_w1(fwd_w1),
      .q_pos(q_pos), .q_neg(q_neg), .v_pos(v_pos), .v_neg(v_neg)
   );

   assign rdata  = clk ? q_pos : q_neg;
   assign rvalid = clk ? v_pos : v_neg;

   // R8: an accepted write occupies the posted stage at its own address
   p_wr_fills_post_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmd |=> (pend_vld && pend_addr == $past(addr)));
   // R5: short latency puts a valid beat in the next high phase
   p_short_lat_beat0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cmd && !lat_sel) |=> ##1 v_pos);
   // R6: long latency puts the second beat in the high phase one cycle later
   p_long_lat_beat1_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cmd && lat_sel && $past(lat_sel)) |=> ##2 v_pos);
   // R7: without a read command no beat is flagged in short latency
   p_no_read_no_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_cmd && !lat_sel) |=> ##1 !v_pos);
endmodule

// File: tb/test_ddr_pair_sram.sv
`timescale 1ns/1ps
module test_ddr_pair_sram;
   localparam int AW = 3, DW = 36, NB = 4, LW = DW / NB;
   localparam int WORDS = 2 ** (AW + 1);

   logic          clk = 1'b0, rst_n = 1'b0, ld_n = 1'b1, rd_nwr = 1'b1, lat_sel = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [NB-1:0] lane_we = '0;
   logic [DW-1:0] rdata;
   logic          rvalid;

   ddr_pair_sram #(.AW(AW), .DW(DW), .NB(NB)) i_ddr_pair_sram (
      .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rd_nwr(rd_nwr), .addr(addr),
      .wdata(wdata), .lane_we(lane_we), .lat_sel(lat_sel), .rdata(rdata), .rvalid(rvalid)
   );

   always #4 clk = ~clk;

   typedef struct { logic [DW-1:0] w0; logic [DW-1:0] w1; int issue; } exp_t;
   exp_t          sb[$];
   logic [DW-1:0] ref_mem [WORDS];
   int            cyc = 0, n_cmp = 0, n_bad = 0;
   bit            done = 0, want_b1 = 0;
   logic [DW-1:0] cur_w1;

   always @(posedge clk) cyc++;

   task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // monitor: hi=1 for the high-phase sample, 0 for the low-phase sample
   task automatic observe(input bit hi);
      bit first_phase;
      exp_t e;
      first_phase = lat_sel ? !hi : hi;
      if (want_b1) begin
         check(rvalid === 1'b1, "R7 beat1 valid", {35'd0, rvalid}, 36'd1);
         check(rdata === cur_w1, "R4 beat1 data", rdata, cur_w1);
         want_b1 = 0;
      end else if (first_phase) begin
         if (rvalid === 1'b1) begin
            if (sb.size() == 0) begin
               check(0, "R7 spurious beat", rdata, '0);
            end else begin
               e = sb.pop_front();
               check(cyc == e.issue + 1, lat_sel ? "R6 latency" : "R5 latency", DW'(cyc), DW'(e.issue + 1));
               check(rdata === e.w0, "R4 beat0 data", rdata, e.w0);
               cur_w1  = e.w1;
               want_b1 = 1;
            end
         end else if (sb.size() > 0 && sb[0].issue + 1 < cyc) begin
            e = sb.pop_front();
            check(0, "R9 missing read", '0, e.w0);
         end
      end else begin
         check(rvalid !== 1'b1, "R7 valid outside beat", {35'd0, rvalid}, 36'd0);
      end
   endtask

   initial begin
      forever begin
         @(posedge clk); #1; if (rst_n) observe(1'b1);
         @(negedge clk); #1; if (rst_n) observe(1'b0);
      end
   end

   // called at falling edge + 2 ns; returns at the next falling edge + 2 ns
   task automatic issue(input logic ldn, input logic rw, input logic [AW-1:0] a,
                        input logic [DW-1:0] d0, input logic [NB-1:0] m0,
                        input logic [DW-1:0] d1, input logic [NB-1:0] m1);
      exp_t e;
      ld_n = ldn; rd_nwr = rw; addr = a; wdata = d0; lane_we = m0;
      if (!ldn && !rw) begin
         for (int l = 0; l < NB; l++) begin
            if (m0[l]) ref_mem[{a, 1'b0}][l*LW +: LW] = d0[l*LW +: LW];
            if (m1[l]) ref_mem[{a, 1'b1}][l*LW +: LW] = d1[l*LW +: LW];
         end
      end else if (!ldn && rw) begin
         e.w0 = ref_mem[{a, 1'b0}]; e.w1 = ref_mem[{a, 1'b1}]; e.issue = cyc + 1;
         sb.push_back(e);
      end
      @(posedge clk); #2;
      wdata = d1; lane_we = m1;
      @(negedge clk); #2;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d0, input logic [NB-1:0] m0,
                     input logic [DW-1:0] d1, input logic [NB-1:0] m1);
      issue(1'b0, 1'b0, a, d0, m0, d1, m1);
   endtask
   task automatic rd(input logic [AW-1:0] a);
      issue(1'b0, 1'b1, a, {DW{1'b1}}, '1, {DW{1'b1}}, '1);
   endtask
   task automatic idle(input int n);
      // R1: ld_n high with junk on every other input starts nothing
      for (int i = 0; i < n; i++)
         issue(1'b1, i[0], AW'(i), {$urandom, 4'hf}, '1, {$urandom, 4'h5}, '1);
   endtask
   task automatic drain();
      idle(4);
      check(sb.size() == 0 && !want_b1, "R9 all reads returned", DW'(sb.size()), '0);
   endtask

   task automatic run_pass(input logic lat);
      @(negedge clk); #2;
      rst_n = 1'b0; lat_sel = lat; ld_n = 1'b1;
      sb.delete(); want_b1 = 0;
      repeat (2) @(negedge clk); #2;
      check(rvalid === 1'b0, "R7 reset state", {35'd0, rvalid}, 36'd0);
      rst_n = 1'b1;
      idle(2);
      // R2: fill every pair with distinct beats, full masks
      for (int a = 0; a < 2 ** AW; a++)
         wr(AW'(a), {4'h1, 28'(a), 4'h0}, '1, {4'h2, 28'(a), 4'h1}, '1);
      idle(2);
      // R4 R9: back-to-back reads of every pair
      for (int a = 0; a < 2 ** AW; a++) rd(AW'(a));
      drain();
      // R3: partial lanes on each beat, read while still posted (R8 merge)
      wr(3'd3, 36'hAAAAAAAAA, 4'b0101, 36'h555555555, 4'b1000);
      idle(1);
      rd(3'd3);
      // R8: commit by a later write, then read from the array
      wr(3'd5, 36'h123456789, 4'b1111, 36'h987654321, 4'b0110);
      rd(3'd3);
      // R8: read right after write to the same pair
      wr(3'd7, 36'hFEDCBA987, 4'b0011, 36'h0F0F0F0F0, 4'b1100);
      rd(3'd7);
      // R3: empty masks change nothing
      wr(3'd1, 36'hDEADBEEF0, 4'b0000, 36'hCAFEF00D1, 4'b0000);
      rd(3'd1);
      wr(3'd2, 36'h111111111, 4'b1111, 36'h222222222, 4'b1111);
      rd(3'd1);
      drain();
      // R1 R9: random mix, no gaps
      for (int i = 0; i < 80; i++) begin
         int k = $urandom_range(0, 3);
         logic [AW-1:0] a = AW'($urandom_range(0, 2 ** AW - 1));
         if (k == 0) idle(1);
         else if (k == 1) wr(a, {$urandom, 4'($urandom)}, NB'($urandom),
                              {$urandom, 4'($urandom)}, NB'($urandom));
         else rd(a);
      end
      drain();
   endtask

   initial begin
      run_pass(1'b0);
      run_pass(1'b1);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run did not finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule